// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Tag Controller

This block makes the hit or miss decision for an external second-level cache that sits between a host bus and main memory. It holds one tag entry per cache line and selects the entry with the index bits of the address. It compares the stored tag with the upper address bits in the same cycle as the request, so the data store can be addressed before the host-bus cycle ends. It also reports whether the addressed line is dirty, and whether the address lies inside the range the tag store can cover. The data SRAM, the memory controller and the fill datapath live outside the block. They are driven by the block's write-to-memory, writeback and line-fill strobes.

The cache size is picked at run time from three steps, each double the one before. Each tag entry has a fixed number of bits. In write-through mode all of them hold address tag. In write-back mode the top bit of the entry holds the dirty flag instead, so the cacheable range is half as large. A read miss on a cacheable address replaces the line. If the line being replaced is dirty, the block first issues a writeback of the old line and then issues the fill. Writes never allocate a line. While a writeback or fill sequence is running the block is busy and ignores requests. The size and mode inputs are static configuration and change only while reset is held.

With default parameters the sizes are 32, 64 and 128 lines of 4 bytes, and each tag entry has 4 bits.

Top module: `l2_tag_ctrl`

## Requirements
- R1: After reset every line is invalid: `busy_o`, `wb_req_o` and `fill_req_o` are low, and the first read of any cacheable line reports `hit_o`=0.
- R2: The line index is the `MIN_IDX_W+s` address bits directly above the `OFFS_W` byte-offset bits, where s is the size step (0, 1, 2). Distinct indices in that field select distinct lines.
- R3: `cacheable_o` is 1 exactly when the address is below 2^(OFFS_W+MIN_IDX_W+s+TAG_RAM_W) in write-through mode, or below half that value in write-back mode. An uncacheable address never hits, never allocates a line and never produces a fill or writeback.
- R4: `hit_o` is 1 when the indexed line is valid and holds the same line address. An accepted read miss on a cacheable address installs that line, so a later read of it hits and a read of another address with the same index misses.
- R5: An accepted read miss on a clean or invalid line raises `fill_req_o` for exactly one cycle, in the cycle after the request, with `xfer_addr_o` equal to the requested address with its offset bits cleared. `busy_o` is high in that cycle only.
- R6: In write-back mode an accepted write hit sets the line's dirty flag. `dirty_o` is 1 on later accesses to that index, and the write is not forwarded to memory (`wr_mem_o`=0).
- R7: In write-back mode an accepted read miss on a dirty line raises `wb_req_o` in the cycle after the request, with `xfer_addr_o` equal to the old line's address. `fill_req_o` follows in the next cycle, and the new line is installed clean.
- R8: In write-through mode `dirty_o` is never 1 and every accepted write raises `wr_mem_o`. In both modes a write miss raises `wr_mem_o` and installs nothing.
- R9: A request made while `busy_o` is high is ignored. It raises no `wr_mem_o` and changes no tag, valid or dirty state.
- R10: Size code 3 behaves exactly like size code 2 (the largest size). Codes 0, 1 and 2 select the smallest, middle and largest size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| size_sel_i | input | 2 | Cache size step: 0 smallest, 1 middle, 2 and 3 largest |
| wb_mode_i | input | 1 | 1 selects write-back, 0 selects write-through |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 for a write access, 0 for a read |
| addr_i | input | ADDR_W | Byte address of the access |
| hit_o | output | 1 | Indexed line valid and tag matches a cacheable address |
| dirty_o | output | 1 | Indexed line valid and dirty (write-back mode) |
| cacheable_o | output | 1 | Address inside the cacheable range |
| wr_mem_o | output | 1 | Accepted write must be forwarded to memory |
| busy_o | output | 1 | Writeback or fill sequence in progress; requests ignored |
| wb_req_o | output | 1 | One-cycle strobe: write the old line back |
| fill_req_o | output | 1 | One-cycle strobe: fetch the line into the cache |
| xfer_addr_o | output | ADDR_W | Line address for the current writeback or fill strobe |

## Verification
The bench uses the defaults: 4-byte lines, 32 to 128 lines, a 4-bit tag entry and a 14-bit address. At these values the whole cacheable range and twice its size fit in the address space. Every line can be swept in each of the eight size and mode combinations, including the reserved size code. Both cacheable-limit boundaries are hit directly, and random traffic over a few indices with many tags produces frequent conflict evictions of dirty lines.

// File: rtl/l2t_pkg.sv
package l2t_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_EVICT = 2'd1,
    SQ_FILL  = 2'd2
  } seq_state_e;

  // reserved code 3 aliases the largest size
  function automatic logic [1:0] size_step(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

endpackage

// File: rtl/l2t_addr_split.sv
module l2t_addr_split #(
  parameter int ADDR_W    = 14,
  parameter int OFFS_W    = 2,
  parameter int MIN_IDX_W = 5,
  parameter int TAG_RAM_W = 4,
  localparam int IDX_W    = MIN_IDX_W + 2
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_sel_i,
  input  logic                 wb_mode_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic [TAG_RAM_W-1:0] tag_o,
  output logic [TAG_RAM_W-1:0] tag_mask_o,
  output logic                 cacheable_o,
  output logic [ADDR_W-1:0]    line_addr_o
);

  logic [1:0]        step;
  int                line_sh;
  int                tag_bits;
  logic [IDX_W-1:0]  idx_mask;
  logic [ADDR_W-1:0] tag_field;
  logic [ADDR_W-1:0] over_field;

  assign step = l2t_pkg::size_step(size_sel_i);

  always_comb begin
    line_sh     = OFFS_W + MIN_IDX_W + int'(step);
    tag_bits    = wb_mode_i ? TAG_RAM_W - 1 : TAG_RAM_W;
    idx_mask    = ~({IDX_W{1'b1}} << (MIN_IDX_W + int'(step)));
    idx_o       = addr_i[OFFS_W +: IDX_W] & idx_mask;
    tag_field   = addr_i >> line_sh;
    tag_o       = tag_field[TAG_RAM_W-1:0];
    tag_mask_o  = wb_mode_i ? {1'b0, {(TAG_RAM_W-1){1'b1}}} : {TAG_RAM_W{1'b1}};
    over_field  = tag_field >> tag_bits;
    cacheable_o = (over_field == '0);
    line_addr_o = addr_i & {{(ADDR_W-OFFS_W){1'b1}}, {OFFS_W{1'b0}}};
  end

endmodule

// File: rtl/l2t_tag_store.sv
module l2t_tag_store #(
  parameter int IDX_W     = 7,
  parameter int TAG_RAM_W = 4,
  localparam int LINES    = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic                 rd_valid_o,
  output logic [TAG_RAM_W-1:0] rd_field_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [TAG_RAM_W-1:0] wr_field_i
);

  logic [LINES-1:0]     valid_q;
  logic [TAG_RAM_W-1:0] field_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // field contents are qualified by valid, no reset needed
  always_ff @(posedge clk_i) begin
    if (wr_en_i) field_q[wr_idx_i] <= wr_field_i;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_field_o = field_q[rd_idx_i];

endmodule

// File: rtl/l2t_seq.sv
module l2t_seq #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              evict_i,
  input  logic [ADDR_W-1:0] victim_addr_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              busy_o,
  output logic              wb_req_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o
);
  import l2t_pkg::*;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] vic_q, fil_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (start_i) state_d = evict_i ? SQ_EVICT : SQ_FILL;
      SQ_EVICT: state_d = SQ_FILL;
      SQ_FILL:  state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      vic_q   <= '0;
      fil_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_i && state_q == SQ_IDLE) begin
        vic_q <= victim_addr_i;
        fil_q <= fill_addr_i;
      end
    end
  end

  assign busy_o      = (state_q != SQ_IDLE);
  assign wb_req_o    = (state_q == SQ_EVICT);
  assign fill_req_o  = (state_q == SQ_FILL);
  assign xfer_addr_o = (state_q == SQ_EVICT) ? vic_q : fil_q;

endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl #(
  parameter int ADDR_W    = 14,
  parameter int OFFS_W    = 2,
  parameter int MIN_IDX_W = 5,
  parameter int TAG_RAM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_sel_i,
  input  logic              wb_mode_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              dirty_o,
  output logic              cacheable_o,
  output logic              wr_mem_o,
  output logic              busy_o,
  output logic              wb_req_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o
);

  localparam int IDX_W = MIN_IDX_W + 2;
  localparam logic [TAG_RAM_W-1:0] DIRTY_BIT = {1'b1, {(TAG_RAM_W-1){1'b0}}};

  logic [IDX_W-1:0]     idx;
  logic [TAG_RAM_W-1:0] cur_tag, tag_mask, st_field, wr_field;
  logic                 st_valid, tag_eq, accept, rd_miss, wr_hit_wb, st_wr;
  logic [ADDR_W-1:0]    line_addr, victim_addr;
  int                   line_sh;

  l2t_addr_split #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .MIN_IDX_W(MIN_IDX_W), .TAG_RAM_W(TAG_RAM_W)
  ) u_split (
    .addr_i(addr_i), .size_sel_i(size_sel_i), .wb_mode_i(wb_mode_i),
    .idx_o(idx), .tag_o(cur_tag), .tag_mask_o(tag_mask),
    .cacheable_o(cacheable_o), .line_addr_o(line_addr)
  );

  l2t_tag_store #(.IDX_W(IDX_W), .TAG_RAM_W(TAG_RAM_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(idx), .rd_valid_o(st_valid), .rd_field_o(st_field),
    .wr_en_i(st_wr), .wr_idx_i(idx), .wr_field_i(wr_field)
  );

  always_comb begin
    tag_eq    = ((st_field ^ cur_tag) & tag_mask) == '0;
    hit_o     = st_valid & cacheable_o & tag_eq;
    dirty_o   = wb_mode_i & st_valid & st_field[TAG_RAM_W-1];
    accept    = req_i & ~busy_o;
    rd_miss   = accept & ~we_i & cacheable_o & ~hit_o;
    wr_hit_wb = accept & we_i & wb_mode_i & hit_o;
    wr_mem_o  = accept & we_i & ~(wb_mode_i & hit_o);
    st_wr     = rd_miss | wr_hit_wb;
    // a fill installs clean; a write-back hit only sets the flag
    wr_field  = rd_miss ? (cur_tag & tag_mask) : (st_field | DIRTY_BIT);
    line_sh   = OFFS_W + MIN_IDX_W + int'(l2t_pkg::size_step(size_sel_i));
    victim_addr = (ADDR_W'(st_field & tag_mask) << line_sh) | (ADDR_W'(idx) << OFFS_W);
  end

  l2t_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(rd_miss), .evict_i(dirty_o),
    .victim_addr_i(victim_addr), .fill_addr_i(line_addr),
    .busy_o(busy_o), .wb_req_o(wb_req_o), .fill_req_o(fill_req_o),
    .xfer_addr_o(xfer_addr_o)
  );

endmodule

// File: rtl/l2_tag_ctrl_chk.sv
module l2_tag_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_mode_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              hit_o,
  input logic              dirty_o,
  input logic              cacheable_o,
  input logic              busy_o,
  input logic              wb_req_o,
  input logic              fill_req_o
);

  a_r5_fill_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |=> !fill_req_o && !busy_o);

  a_r7_evict_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |=> fill_req_o && !wb_req_o);

  a_r3_uncacheable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !cacheable_o |=> !fill_req_o && !wb_req_o);

  a_r4_read_miss_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && !we_i && cacheable_o && !hit_o |=> busy_o);

  a_r6_write_hit_dirties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && we_i && wb_mode_i && hit_o |=> ($stable(addr_i) |-> dirty_o));

  a_r9_busy_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !wb_req_o |=> !busy_o);

endmodule

bind l2_tag_ctrl l2_tag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wb_mode_i(wb_mode_i), .req_i(req_i),
  .we_i(we_i), .addr_i(addr_i), .hit_o(hit_o), .dirty_o(dirty_o),
  .cacheable_o(cacheable_o), .busy_o(busy_o), .wb_req_o(wb_req_o),
  .fill_req_o(fill_req_o)
);

// File: tb/l2_tag_ctrl_bench.sv
module l2_tag_ctrl_bench;
  localparam int ADDR_W    = 14;
  localparam int OFFS_W    = 2;
  localparam int MIN_IDX_W = 5;
  localparam int TAG_RAM_W = 4;
  localparam int MAXL      = 1 << (MIN_IDX_W + 2);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic [1:0] size_sel = 2'd0;
  logic wb_mode = 1'b0, req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic hit, dirty, cach, wr_mem, busy, wb_req, fill_req;
  logic [ADDR_W-1:0] xfer;

  l2_tag_ctrl #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .MIN_IDX_W(MIN_IDX_W),
                .TAG_RAM_W(TAG_RAM_W)) u_l2_tag_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .size_sel_i(size_sel), .wb_mode_i(wb_mode),
    .req_i(req), .we_i(we), .addr_i(addr), .hit_o(hit), .dirty_o(dirty),
    .cacheable_o(cach), .wr_mem_o(wr_mem), .busy_o(busy), .wb_req_o(wb_req),
    .fill_req_o(fill_req), .xfer_addr_o(xfer)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit m_v [MAXL];
  bit m_d [MAXL];
  int m_ln [MAXL];
  int cfg_wb, nl, base, limit;

  task automatic chk(string rq, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic configure(int sel, int wbm);
    int sz;
    @(negedge clk);
    rst_ni = 1'b0; req = 1'b0;
    size_sel = 2'(sel); wb_mode = wbm[0]; cfg_wb = wbm;
    sz = (sel == 3) ? 2 : sel;   // R10: code 3 aliases the largest size
    nl = 1 << (MIN_IDX_W + sz);
    base = OFFS_W + MIN_IDX_W + sz;
    limit = 1 << (base + TAG_RAM_W - wbm);
    for (int k = 0; k < MAXL; k++) begin m_v[k] = 0; m_d[k] = 0; m_ln[k] = 0; end
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #2;
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "strobes after reset", int'(wb_req | fill_req), 0);
    @(negedge clk);
  endtask

  // entered and left at a falling edge
  task automatic access(int a, int w, string lbl);
    int i, ln;
    bit e_c, e_h, e_d, e_f, e_e, e_m;
    e_c = a < limit;
    ln  = a >> OFFS_W;
    i   = ln & (nl - 1);
    e_h = e_c && m_v[i] && m_ln[i] == ln;
    e_d = cfg_wb != 0 && m_v[i] && m_d[i];
    e_f = w == 0 && e_c && !e_h;
    e_e = e_f && e_d;
    e_m = w != 0 && !(cfg_wb != 0 && e_h);
    req = 1'b1; we = w[0]; addr = ADDR_W'(a);
    #2;
    chk({"R3 ", lbl}, "cacheable", int'(cach), int'(e_c));
    chk({"R4 ", lbl}, "hit", int'(hit), int'(e_h));
    chk({"R6 ", lbl}, "dirty", int'(dirty), int'(e_d));
    chk({"R8 ", lbl}, "wr_mem", int'(wr_mem), int'(e_m));
    @(negedge clk);
    if (e_f) begin
      we = 1'b1;   // R9: a write offered while busy must be ignored
      if (e_e) begin
        #2;
        chk({"R7 ", lbl}, "wb_req", int'(wb_req), 1);
        chk({"R7 ", lbl}, "victim addr", int'(xfer), m_ln[i] << OFFS_W);
        chk({"R9 ", lbl}, "wr_mem while busy", int'(wr_mem), 0);
        @(negedge clk);
      end
      #2;
      chk({"R5 ", lbl}, "fill_req", int'(fill_req), 1);
      chk({"R5 ", lbl}, "wb_req during fill", int'(wb_req), 0);
      chk({"R5 ", lbl}, "fill addr", int'(xfer), ln << OFFS_W);
      chk({"R9 ", lbl}, "wr_mem while busy", int'(wr_mem), 0);
      @(negedge clk);
      m_v[i] = 1; m_ln[i] = ln; m_d[i] = 0;
    end else begin
      #2;
      chk({"R5 ", lbl}, "busy without miss", int'(busy | fill_req | wb_req), 0);
      @(negedge clk);
      if (w != 0 && cfg_wb != 0 && e_h) m_d[i] = 1;
    end
    req = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      int sel, wbm, tb;
      sel = c >> 1; wbm = c & 1;
      configure(sel, wbm);
      tb = TAG_RAM_W - wbm;
      for (int k = 0; k < nl; k++) access(k << OFFS_W, 0, "R1 first touch");
      for (int k = 0; k < nl; k++) access((k << OFFS_W) | 1, 0, "R2 index reuse");
      for (int k = 0; k < nl; k++) access(k << OFFS_W, 1, "R8 write sweep");
      for (int k = 0; k < nl; k++) access((1 << base) | (k << OFFS_W), 0, "R7 conflict");
      access(limit, 0, "R3 limit");
      access(limit - 1, 0, "R3 limit-1");
      access(limit - 1, 0, "R3 limit-1 again");
      for (int k = 0; k < 500; k++) begin
        int t, ix, of, a;
        t  = $urandom_range(0, (1 << (tb + 1)) - 1);
        ix = $urandom_range(0, 7);
        of = $urandom_range(0, (1 << OFFS_W) - 1);
        a  = (t << base) | (ix << OFFS_W) | of;
        access(a, ($urandom_range(0, 2) == 0) ? 1 : 0, sel == 3 ? "R10 alias random" : "random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule